// File: doc/BRIEF.md
# Memory-Mapped Keyboard Input Port

This block connects a keyboard-style character source to a simple 16-bit processor through two registers in the processor's memory map. The device side presents an 8-bit character code together with a one-cycle valid strobe. The port latches the first character that arrives while it is idle and raises a ready flag. It then ignores further characters until software reads the data register. That read clears the flag and opens the port for the next keystroke.

On the processor side the block decodes the address and returns the read data. This is either a device register or, when the address matches neither register, the word supplied by memory. The port also raises an interrupt request whenever a character is waiting and software has set the enable bit. Software polls the status word, or waits for the interrupt, and then reads the data word.

Top module: `kbd_mmio_port`

## Requirements
- R1: The status register decodes at address 0xFE00 and the data register at 0xFE02. At any other address, cpu_rdata equals mem_rdata. Read data is combinational in the same cycle.
- R2: A status read returns the ready flag in bit 15 and the interrupt enable in bit 14. All other bits read as zero.
- R3: A data read returns the latched code in bits 7:0, and bits 15:8 read as zero.
- R4: When key_valid is high and ready is 0, the code is latched at that clock edge and ready reads as 1 from the next cycle.
- R5: While ready is 1, incoming characters are dropped. The latched code does not change, and nothing is queued behind it.
- R6: A read of the data register (cpu_rd high at 0xFE02) clears ready at the next edge. If a character arrives in that same cycle while ready is 1, the read returns the old code and the new character is lost.
- R7: irq is high exactly when ready and the interrupt enable are both 1.
- R8: A write to the status register sets the interrupt enable from cpu_wdata bit 14. The write leaves ready unchanged. Writes to the data register or to other addresses change no register.
- R9: While rst_n is low at a clock edge, ready, the interrupt enable and the latched code are cleared.
- R10: Reading the status register does not clear ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | Character strobe from the device side |
| key_code | input | 8 | Character code from the device side |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 16 | Processor write data |
| mem_rdata | input | 16 | Read data from memory for unmapped addresses |
| cpu_rdata | output | 16 | Read data returned to the memory-data path |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets a keystroke that lands in the same cycle as a data read. A design that let capture win there would overwrite the unread code or leave ready set. Keystrokes arriving while ready is held are also checked: a port that overwrote the latch would return the newest code instead of the first. Status writes carrying all ones are checked as well, since they would expose a writable ready bit or stray set bits. Finally, reads at neighbouring addresses such as 0xFE04 must pass memory data through, or a sloppy decode would show up.

// File: rtl/kbd_pkg.sv
// Package: shared constants and the decode-select type for the keyboard port.
// Assumes a 16-bit address and data path with 8-bit character codes.
package kbd_pkg;
    localparam int unsigned KB_ADDR_W = 16;
    localparam int unsigned KB_DATA_W = 16;
    localparam int unsigned KB_CODE_W = 8;
    localparam logic [KB_ADDR_W-1:0] KB_STAT_ADDR = 16'hFE00;
    localparam logic [KB_ADDR_W-1:0] KB_DATA_ADDR = 16'hFE02;

    typedef enum logic [1:0] {
        SEL_MEM  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2
    } kb_sel_e;
endpackage

// File: rtl/kbd_addr_decode.sv
// Address decoder: classifies a processor address as status, data or memory.
// Assumes the two register addresses differ; a full-width compare is used.
module kbd_addr_decode
    import kbd_pkg::*;
#(
    parameter int unsigned ADDR_W = KB_ADDR_W,
    parameter logic [ADDR_W-1:0] STAT_ADDR = KB_STAT_ADDR,
    parameter logic [ADDR_W-1:0] DATA_ADDR = KB_DATA_ADDR
) (
    input  logic [ADDR_W-1:0] addr,
    output kb_sel_e           sel
);
    // Select the read source from the address.
    always_comb begin
        if (addr == STAT_ADDR)      sel = SEL_STAT;
        else if (addr == DATA_ADDR) sel = SEL_DATA;
        else                        sel = SEL_MEM;
    end
endmodule

// File: rtl/kbd_capture.sv
// Character capture: latches one code, holds it with a ready flag, and drops
// later codes until an acknowledge (data-register read) clears the flag.
// Assumes key_valid is a single-cycle strobe per character.
module kbd_capture #(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CODE_W-1:0] key_code,
    input  logic              rd_ack,
    output logic              ready,
    output logic [CODE_W-1:0] code
);
    // Ready flag: set on capture when idle, cleared by acknowledge when full.
    always_ff @(posedge clk) begin
        if (!rst_n)     ready <= 1'b0;
        else if (ready) ready <= !rd_ack;
        else            ready <= key_valid;
    end

    // Code latch: loads only while idle, so a held code is never overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n)                   code <= '0;
        else if (!ready && key_valid) code <= key_code;
    end

    AST_CAPTURE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && key_valid) |=> (ready && code == $past(key_code))); // R4
    AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rd_ack) |=> (ready && $stable(code))); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rd_ack) |=> (!ready && $stable(code))); // R6
endmodule

// File: rtl/kbd_int_ctrl.sv
// Interrupt control: holds the software-written enable and forms the request.
// Assumes the caller qualifies wr_en with a status-register address match.
module kbd_int_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic ready,
    output logic ie,
    output logic irq
);
    // Enable bit: loaded from the written data on a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= 1'b0;
        else if (wr_en) ie <= wr_bit;
    end

    // Request: a waiting character with interrupts enabled.
    assign irq = ready & ie;

    AST_IE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ie == $past(wr_bit))); // R8
    AST_IE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ie)); // R8
endmodule

// File: rtl/kbd_mmio_port.sv
// Keyboard input port top: address decode, status/data registers, interrupt
// request and read-back mux onto the memory-data path.
// Assumes single-cycle combinational reads; cpu_rd/cpu_wr are not both high.
module kbd_mmio_port
    import kbd_pkg::*;
#(
    parameter int unsigned ADDR_W = KB_ADDR_W,
    parameter int unsigned DATA_W = KB_DATA_W,
    parameter int unsigned CODE_W = KB_CODE_W,
    parameter logic [ADDR_W-1:0] STAT_ADDR = KB_STAT_ADDR,
    parameter logic [ADDR_W-1:0] DATA_ADDR = KB_DATA_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CODE_W-1:0] key_code,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              irq
);
    localparam int unsigned RDY_BIT = DATA_W - 1;
    localparam int unsigned IE_BIT  = DATA_W - 2;

    kb_sel_e           sel;
    logic              rd_ack;
    logic              wr_stat;
    logic              ready;
    logic              ie;
    logic [CODE_W-1:0] code;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] data_word;
    logic              unused_wdata;

    kbd_addr_decode #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) u_dec (
        .addr (cpu_addr),
        .sel  (sel)
    );

    // Strobe qualification: data reads acknowledge, status writes load enable.
    assign rd_ack  = cpu_rd && (sel == SEL_DATA);
    assign wr_stat = cpu_wr && (sel == SEL_STAT);

    kbd_capture #(.CODE_W(CODE_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_code  (key_code),
        .rd_ack    (rd_ack),
        .ready     (ready),
        .code      (code)
    );

    kbd_int_ctrl u_int (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_stat),
        .wr_bit (cpu_wdata[IE_BIT]),
        .ready  (ready),
        .ie     (ie),
        .irq    (irq)
    );

    // Only the enable bit of write data is used.
    assign unused_wdata = &{1'b0, cpu_wdata};

    // Status word: flags in the top two bits, zeros elsewhere.
    always_comb begin
        stat_word          = '0;
        stat_word[RDY_BIT] = ready;
        stat_word[IE_BIT]  = ie;
    end

    // Data word: code zero-extended to the bus width.
    assign data_word = {{(DATA_W-CODE_W){1'b0}}, code};

    // Read-back mux onto the memory-data path.
    always_comb begin
        case (sel)
            SEL_STAT: cpu_rdata = stat_word;
            SEL_DATA: cpu_rdata = data_word;
            default:  cpu_rdata = mem_rdata;
        endcase
    end

    AST_MEM_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr != STAT_ADDR && cpu_addr != DATA_ADDR) |-> (cpu_rdata == mem_rdata)); // R1
    AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == DATA_ADDR) |-> (cpu_rdata[DATA_W-1:CODE_W] == '0)); // R3
    AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == STAT_ADDR) |-> (irq == (cpu_rdata[RDY_BIT] & cpu_rdata[IE_BIT]))); // R7
    AST_STATUS_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == STAT_ADDR && cpu_rdata[RDY_BIT]) |=> ready); // R10
    AST_STATUS_WRITE_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !key_valid) |=> (ready == $past(ready))); // R8
endmodule

// File: tb/kbd_mmio_port_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against a
// behavioural model held in bench variables.
module kbd_mmio_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [7:0]  key_code = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] cpu_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    bit       m_ready = 0;
    bit       m_ie = 0;
    bit [7:0] m_code = '0;

    kbd_mmio_port uut (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .mem_rdata(mem_rdata),
        .cpu_rdata(cpu_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] exp_rdata(input logic [15:0] a, input logic [15:0] m);
        if (a == 16'hFE00)      return {m_ready, m_ie, 14'b0};
        else if (a == 16'hFE02) return {8'h00, m_code};
        else                    return m;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive, compare outputs mid-cycle, advance the model.
    task automatic step(input logic [15:0] a, input bit rd, input bit wr,
                        input logic [15:0] wd, input bit kv, input logic [7:0] kc,
                        input string req);
        @(posedge clk); #1;
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
        key_valid = kv; key_code = kc; mem_rdata = 16'($urandom);
        @(negedge clk);
        check(req, cpu_rdata, exp_rdata(a, mem_rdata));
        check({req, "/R7 irq"}, {15'b0, irq}, {15'b0, m_ready & m_ie});
        if (wr && a == 16'hFE00) m_ie = wd[14];
        if (m_ready) begin
            if (rd && a == 16'hFE02) m_ready = 0;
        end else if (kv) begin
            m_ready = 1; m_code = kc;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R9: reset with stimulus pending
        key_valid = 1'b1; key_code = 8'hAA; cpu_wr = 1'b1; cpu_addr = 16'hFE00; cpu_wdata = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1; key_valid = 1'b0; cpu_wr = 1'b0;
        step(16'hFE00, 1, 0, 0, 0, 0, "R9 status after reset");
        step(16'hFE02, 1, 0, 0, 0, 0, "R9 data after reset");
        // R1: neighbour addresses pass memory data
        step(16'hFE04, 1, 0, 0, 0, 0, "R1 FE04");
        step(16'hFE01, 1, 0, 0, 0, 0, "R1 FE01");
        step(16'h0000, 1, 0, 0, 0, 0, "R1 zero");
        // R4: capture when idle
        step(16'hFE00, 1, 0, 0, 1, 8'h41, "R4 capture");
        step(16'hFE00, 1, 0, 0, 0, 0, "R4 ready set");
        // R5: further keys dropped
        step(16'hFE00, 0, 0, 0, 1, 8'h42, "R5 drop");
        step(16'hFE02, 0, 0, 0, 1, 8'h43, "R5 code held");
        // R10: status read keeps ready
        step(16'hFE00, 1, 0, 0, 0, 0, "R10 status read");
        step(16'hFE00, 1, 0, 0, 0, 0, "R10 still ready");
        // R8: status write all ones sets only enable; data write ignored
        step(16'hFE00, 0, 1, 16'hFFFF, 0, 0, "R8 write ones");
        step(16'hFE00, 1, 0, 0, 0, 0, "R8/R7 after write");
        step(16'hFE02, 0, 1, 16'h00FF, 0, 0, "R8 data write");
        step(16'hFE02, 1, 0, 0, 1, 8'h55, "R6 read with arrival");
        step(16'hFE00, 1, 0, 0, 0, 0, "R6 cleared");
        step(16'hFE02, 1, 0, 0, 0, 0, "R6 old code kept");
        // R4: capture after reopen, R3 upper zero with code 0xFF
        step(16'hFE00, 0, 0, 0, 1, 8'hFF, "R4 recapture");
        step(16'hFE02, 1, 0, 0, 0, 0, "R3 code FF");
        step(16'hFE00, 0, 1, 16'h8000, 0, 0, "R8 clear enable");
        step(16'hFE00, 1, 0, 0, 0, 0, "R2 R7 enable off");
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            int pick;
            pick = $urandom_range(0, 9);
            if (pick < 4)      a = 16'hFE00;
            else if (pick < 8) a = 16'hFE02;
            else if (pick < 9) a = 16'hFE00 + 16'($urandom_range(1, 7));
            else               a = 16'($urandom);
            begin
                bit rd;
                bit wr;
                rd = ($urandom_range(0, 2) == 0);
                wr = !rd && ($urandom_range(0, 3) == 0);
                step(a, rd, wr, 16'($urandom), ($urandom_range(0, 2) == 0), 8'($urandom),
                     (a == 16'hFE00) ? "R2 rnd status" : (a == 16'hFE02) ? "R3 rnd data" : "R1 rnd mem");
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule